// File: doc/BRIEF.md
# TLB Lockdown Region Controller

This block is a small fully associative translation cache split into two regions: a pinned region whose entries software fills on purpose, and an unlocked region that holds ordinary refills. A page-walk engine hands finished walk results to the refill port. A single control word steers those refills. Its keep bit sends each refill into the pinned slot that the victim pointer names, and the pointer then moves to the next slot by itself. With the keep bit clear, refills land in the unlocked region in rotating order.

Lookups answer in the same cycle with a hit flag and a physical page number. Three invalidate commands maintain the contents. The bulk command empties only the unlocked region, so pinned translations survive it. The address and ASID commands reach into both regions. Software pins a translation by setting the keep bit with a read-modify-write of the control word, causing a miss on the chosen address, and then clearing the bit again.

Top module: `tlb_lock_ctrl`

## Requirements
- R1: Operation code 1 (bulk) clears every unlocked entry and leaves every pinned entry unchanged.
- R2: Operation code 2 clears every entry in either region whose page number equals `op_vpn`, whatever its ASID or global flag.
- R3: Operation code 3 clears every non-global entry in either region whose ASID equals `op_asid`. Global entries stay.
- R4: The control word holds the keep bit in bit 0 and the victim pointer in bits [28:26]; all other bits read zero. Each refill taken into the pinned region advances the pointer by one, wrapping from 7 to 0. A read returns the advanced value.
- R5: While the keep bit is 1, each refill is written into the pinned entry selected by the victim pointer, and no unlocked entry changes.
- R6: While the keep bit is 0, refills go to the unlocked region in round-robin order, so the ninth of nine back-to-back refills replaces the first. The victim pointer and keep bit do not change.
- R7: A lookup hits in the same cycle when a valid entry's page number matches `lk_vpn` and the entry is global or its ASID equals `lk_asid`. On a miss `lk_ppn` is zero.
- R8: When both regions hit, the pinned entry's physical page is returned.
- R9: An invalidate and a refill in the same cycle act invalidate first, so the refilled entry is valid afterwards even if it matches the invalidate.
- R10: Reset clears every valid bit, the victim pointer and the keep bit. The control word reads 0 and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current address space ID for lookups |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, zero on miss |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill ASID |
| rf_global | input | 1 | Refill global flag |
| rf_ppn | input | 20 | Refill physical page |
| op_valid | input | 1 | Invalidate command strobe |
| op_kind | input | 2 | 1 bulk unlocked, 2 by page, 3 by ASID |
| op_vpn | input | 20 | Page number for operation 2 |
| op_asid | input | 8 | ASID for operation 3 |
| cr_wr | input | 1 | Control word write strobe |
| cr_wdata | input | 32 | Control word write data |
| cr_rdata | output | 32 | Control word read data |

## Verification
A wrong victim pointer shows in `cr_rdata` on the first read after the refill that moved it. It also shows later as a pinned translation that vanishes after a bulk invalidate, because that translation landed in the wrong slot or region. A stuck valid bit or a mis-steered refill becomes visible on the next lookup of that page: a stale hit, a miss, or the unlocked page returned where the pinned one should win. Each of these faults appears no more than one or two cycles after the command that exposes it.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
   typedef enum logic [1:0] {
      TLB_OP_NONE     = 2'd0,
      TLB_OP_INV_FREE = 2'd1,
      TLB_OP_INV_VA   = 2'd2,
      TLB_OP_INV_ASID = 2'd3
   } tlb_op_e;
endpackage

// File: rtl/tlb_bank.sv
// One region of entries: storage, invalidate kill logic and priority lookup.
module tlb_bank
   import tlbl_pkg::*;
#(
   parameter int N      = 8,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int ASID_W = 8,
   parameter bit PINNED = 1'b0,
   localparam int IW    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  tlb_op_e           op_kind,
   input  logic [VPN_W-1:0]  op_vpn,
   input  logic [ASID_W-1:0] op_asid,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glb,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic [N-1:0]      valid_o
);

   logic                       bulk_kill;
   logic [N-1:0]               hit_vec;
   logic [N-1:0][PPN_W-1:0]    ppn_all;

   // The bulk command reaches only regions that are not pinned.
   if (PINNED) begin : g_keep
      assign bulk_kill = 1'b0;
   end else begin : g_drop
      assign bulk_kill = op_valid && (op_kind == TLB_OP_INV_FREE);
   end

   for (genvar e = 0; e < N; e++) begin : g_ent
      logic              vld_r;
      logic              glb_r;
      logic [VPN_W-1:0]  vpn_r;
      logic [ASID_W-1:0] asid_r;
      logic [PPN_W-1:0]  ppn_r;
      logic              kill;

      assign kill = bulk_kill
                  | (op_valid && (op_kind == TLB_OP_INV_VA) && (vpn_r == op_vpn))
                  | (op_valid && (op_kind == TLB_OP_INV_ASID) && !glb_r && (asid_r == op_asid));

      // Write after kill: a refill in the same cycle survives.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_r  <= 1'b0;
            glb_r  <= 1'b0;
            vpn_r  <= '0;
            asid_r <= '0;
            ppn_r  <= '0;
         end else if (wr_en && (wr_idx == IW'(e))) begin
            vld_r  <= 1'b1;
            glb_r  <= wr_glb;
            vpn_r  <= wr_vpn;
            asid_r <= wr_asid;
            ppn_r  <= wr_ppn;
         end else if (kill) begin
            vld_r  <= 1'b0;
         end
      end

      assign hit_vec[e] = vld_r && (vpn_r == lk_vpn) && (glb_r || (asid_r == lk_asid));
      assign ppn_all[e] = ppn_r;
      assign valid_o[e] = vld_r;
   end

   // Lowest matching index wins.
   always_comb begin
      hit     = |hit_vec;
      hit_ppn = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_ppn = ppn_all[i];
      end
   end

endmodule

// File: rtl/tlb_victim_reg.sv
// Control word: keep bit and auto-advancing victim pointer.
module tlb_victim_reg #(
   parameter int DATA_W = 32,
   parameter int VW     = 3,
   parameter int VLSB   = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bump,
   output logic [VW-1:0]     victim,
   output logic              preserve,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim   <= '0;
         preserve <= 1'b0;
      end else if (wr) begin
         victim   <= wdata[VLSB +: VW];
         preserve <= wdata[0];
      end else if (bump) begin
         victim   <= victim + 1'b1;
      end
   end

   always_comb begin
      rdata              = '0;
      rdata[VLSB +: VW]  = victim;
      rdata[0]           = preserve;
   end

endmodule

// File: rtl/tlb_lock_ctrl.sv
// Two-region translation cache with a software-pinned region.
module tlb_lock_ctrl
   import tlbl_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int LOCK_N = 8,
   parameter int FREE_N = 8,
   parameter int DATA_W = 32,
   parameter int VLSB   = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   input  logic              rf_valid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [ASID_W-1:0] rf_asid,
   input  logic              rf_global,
   input  logic [PPN_W-1:0]  rf_ppn,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [VPN_W-1:0]  op_vpn,
   input  logic [ASID_W-1:0] op_asid,
   input  logic              cr_wr,
   input  logic [DATA_W-1:0] cr_wdata,
   output logic [DATA_W-1:0] cr_rdata
);

   localparam int LVW = $clog2(LOCK_N);
   localparam int FVW = $clog2(FREE_N);

   if (LOCK_N < 2 || (1 << LVW) != LOCK_N) begin : g_chk_lock
      $error("LOCK_N must be a power of two of at least 2");
   end
   if (FREE_N < 2 || (1 << FVW) != FREE_N) begin : g_chk_free
      $error("FREE_N must be a power of two of at least 2");
   end
   if (VLSB < 1 || VLSB + LVW > DATA_W) begin : g_chk_field
      $error("victim field must fit above bit 0 of the control word");
   end

   tlb_op_e           op_e;
   logic [LVW-1:0]    victim_q;
   logic              preserve_q;
   logic [FVW-1:0]    rr_q;
   logic              lock_wr;
   logic              free_wr;
   logic              l_hit;
   logic              f_hit;
   logic [PPN_W-1:0]  l_ppn;
   logic [PPN_W-1:0]  f_ppn;
   logic [LOCK_N-1:0] lock_vld;
   logic [FREE_N-1:0] free_vld;

   assign op_e    = tlb_op_e'(op_kind);
   assign lock_wr = rf_valid && preserve_q;
   assign free_wr = rf_valid && !preserve_q;

   tlb_victim_reg #(
      .DATA_W (DATA_W),
      .VW     (LVW),
      .VLSB   (VLSB)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cr_wr),
      .wdata    (cr_wdata),
      .bump     (lock_wr),
      .victim   (victim_q),
      .preserve (preserve_q),
      .rdata    (cr_rdata)
   );

   // Round-robin replacement for the unlocked region.
   always_ff @(posedge clk) begin
      if (!rst_n)       rr_q <= '0;
      else if (free_wr) rr_q <= rr_q + 1'b1;
   end

   tlb_bank #(
      .N      (LOCK_N),
      .VPN_W  (VPN_W),
      .PPN_W  (PPN_W),
      .ASID_W (ASID_W),
      .PINNED (1'b1)
   ) i_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_kind  (op_e),
      .op_vpn   (op_vpn),
      .op_asid  (op_asid),
      .wr_en    (lock_wr),
      .wr_idx   (victim_q),
      .wr_vpn   (rf_vpn),
      .wr_asid  (rf_asid),
      .wr_glb   (rf_global),
      .wr_ppn   (rf_ppn),
      .lk_vpn   (lk_vpn),
      .lk_asid  (lk_asid),
      .hit      (l_hit),
      .hit_ppn  (l_ppn),
      .valid_o  (lock_vld)
   );

   tlb_bank #(
      .N      (FREE_N),
      .VPN_W  (VPN_W),
      .PPN_W  (PPN_W),
      .ASID_W (ASID_W),
      .PINNED (1'b0)
   ) i_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_kind  (op_e),
      .op_vpn   (op_vpn),
      .op_asid  (op_asid),
      .wr_en    (free_wr),
      .wr_idx   (rr_q),
      .wr_vpn   (rf_vpn),
      .wr_asid  (rf_asid),
      .wr_glb   (rf_global),
      .wr_ppn   (rf_ppn),
      .lk_vpn   (lk_vpn),
      .lk_asid  (lk_asid),
      .hit      (f_hit),
      .hit_ppn  (f_ppn),
      .valid_o  (free_vld)
   );

   // Pinned region has priority.
   assign lk_hit = l_hit | f_hit;
   assign lk_ppn = l_hit ? l_ppn : f_ppn;

endmodule

// File: rtl/tlb_lock_ctrl_chk.sv
module tlb_lock_ctrl_chk #(
   parameter int LOCK_N = 8,
   parameter int FREE_N = 8,
   localparam int LVW   = $clog2(LOCK_N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rf_valid,
   input logic              op_valid,
   input logic [1:0]        op_kind,
   input logic              cr_wr,
   input logic [LVW-1:0]    victim,
   input logic              preserve,
   input logic [LOCK_N-1:0] lock_vld,
   input logic [FREE_N-1:0] free_vld
);

   // R1: bulk command keeps pinned entries
   a_r1_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'd1 && !(rf_valid && preserve)) |=> (lock_vld == $past(lock_vld)));

   // R1: bulk command empties unlocked region
   a_r1_free_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'd1 && !(rf_valid && !preserve)) |=> (free_vld == '0));

   // R4: pinned refill advances the victim pointer
   a_r4_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && preserve && !cr_wr) |=> (victim == LVW'($past(victim) + 1'b1)));

   // R5: pinned refill fills the selected slot
   a_r5_lock_filled: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && preserve) |=> lock_vld[$past(victim)]);

   // R5: pinned refill leaves the unlocked region alone
   a_r5_free_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && preserve && !op_valid) |=> $stable(free_vld));

   // R6: unlocked refill holds the control word
   a_r6_victim_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !preserve && !cr_wr) |=> ($stable(victim) && $stable(preserve)));

endmodule

bind tlb_lock_ctrl tlb_lock_ctrl_chk #(
   .LOCK_N (LOCK_N),
   .FREE_N (FREE_N)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rf_valid (rf_valid),
   .op_valid (op_valid),
   .op_kind  (op_kind),
   .cr_wr    (cr_wr),
   .victim   (victim_q),
   .preserve (preserve_q),
   .lock_vld (lock_vld),
   .free_vld (free_vld)
);

// File: tb/test_tlb_lock_ctrl.sv
`timescale 1ns/1ps
module test_tlb_lock_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_hit;
   logic [19:0] lk_ppn;
   logic        rf_valid = 1'b0;
   logic [19:0] rf_vpn = '0;
   logic [7:0]  rf_asid = '0;
   logic        rf_global = 1'b0;
   logic [19:0] rf_ppn = '0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = '0;
   logic [19:0] op_vpn = '0;
   logic [7:0]  op_asid = '0;
   logic        cr_wr = 1'b0;
   logic [31:0] cr_wdata = '0;
   logic [31:0] cr_rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   tlb_lock_ctrl i_tlb_lock_ctrl (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
      .rf_global(rf_global), .rf_ppn(rf_ppn),
      .op_valid(op_valid), .op_kind(op_kind), .op_vpn(op_vpn), .op_asid(op_asid),
      .cr_wr(cr_wr), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata)
   );

   // {kind 0=refill 1=lookup, vpn, asid, global, ppn, exp_hit, exp_ppn}
   localparam int VW = 73;
   localparam logic [VW-1:0] VEC [0:6] = '{
      {3'd0, 20'h00012, 8'd1, 1'b0, 20'hAAAAA, 1'b0, 20'h0},
      {3'd0, 20'h00034, 8'd2, 1'b1, 20'hBBBBB, 1'b0, 20'h0},
      {3'd1, 20'h00012, 8'd1, 1'b0, 20'h0,     1'b1, 20'hAAAAA},
      {3'd1, 20'h00012, 8'd2, 1'b0, 20'h0,     1'b0, 20'h0},
      {3'd1, 20'h00034, 8'd9, 1'b0, 20'h0,     1'b1, 20'hBBBBB},
      {3'd1, 20'h00035, 8'd2, 1'b0, 20'h0,     1'b0, 20'h0},
      {3'd1, 20'h00034, 8'd2, 1'b0, 20'h0,     1'b1, 20'hBBBBB}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic refill(input logic [19:0] v, input logic [7:0] a, input logic g, input logic [19:0] p);
      @(negedge clk);
      rf_valid = 1'b1; rf_vpn = v; rf_asid = a; rf_global = g; rf_ppn = p;
      @(negedge clk);
      rf_valid = 1'b0;
   endtask

   task automatic do_op(input logic [1:0] k, input logic [19:0] v, input logic [7:0] a);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_vpn = v; op_asid = a;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [31:0] d);
      @(negedge clk);
      cr_wr = 1'b1; cr_wdata = d;
      @(negedge clk);
      cr_wr = 1'b0;
   endtask

   task automatic rd_ctrl(input string req, input logic [31:0] exp);
      @(negedge clk);
      #1;
      chk(req, cr_rdata, exp);
   endtask

   task automatic look(input string req, input logic [19:0] v, input logic [7:0] a,
                       input logic eh, input logic [19:0] ep);
      @(negedge clk);
      lk_vpn = v; lk_asid = a;
      #1;
      chk(req, {11'd0, lk_hit, lk_ppn}, {11'd0, eh, ep});
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      rd_ctrl("R10 ctrl after reset", 32'h0);
      look("R10 lookup after reset", 20'h00012, 8'd1, 1'b0, 20'h0);

      // R7: table of refills and lookups, keep bit clear
      for (int i = 0; i < 7; i++) begin
         if (VEC[i][72:70] == 3'd0)
            refill(VEC[i][69:50], VEC[i][49:42], VEC[i][41], VEC[i][40:21]);
         else
            look("R7 table lookup", VEC[i][69:50], VEC[i][49:42], VEC[i][20], VEC[i][19:0]);
      end

      // R5/R4: pinned refill into slot 0, pointer advances
      wr_ctrl(32'h0000_0001);
      rd_ctrl("R4 keep bit read", 32'h0000_0001);
      refill(20'h00100, 8'd3, 1'b0, 20'h11100);
      rd_ctrl("R4 victim advanced", 32'h0400_0001);

      // R1: bulk command keeps pinned, drops unlocked
      do_op(2'd1, 20'h0, 8'd0);
      look("R1 pinned survives", 20'h00100, 8'd3, 1'b1, 20'h11100);
      look("R1 unlocked cleared", 20'h00012, 8'd1, 1'b0, 20'h0);
      look("R1 unlocked global cleared", 20'h00034, 8'd2, 1'b0, 20'h0);

      // R4: wrap from 7 to 0
      wr_ctrl(32'h1C00_0001);
      refill(20'h00300, 8'd3, 1'b0, 20'h0AAAA);
      rd_ctrl("R4 victim wraps", 32'h0000_0001);

      // R6: keep bit clear, pointer holds; R8 pinned wins over newer unlocked
      wr_ctrl(32'h0800_0000);
      refill(20'h00300, 8'd3, 1'b0, 20'h0BBBB);
      rd_ctrl("R6 victim unchanged", 32'h0800_0000);
      look("R8 pinned priority", 20'h00300, 8'd3, 1'b1, 20'h0AAAA);

      // R2: invalidate by page across both regions
      refill(20'h00100, 8'd4, 1'b0, 20'h22200);
      look("R2 setup unlocked", 20'h00100, 8'd4, 1'b1, 20'h22200);
      do_op(2'd2, 20'h00100, 8'd0);
      look("R2 pinned cleared", 20'h00100, 8'd3, 1'b0, 20'h0);
      look("R2 unlocked cleared", 20'h00100, 8'd4, 1'b0, 20'h0);

      // R3: invalidate by ASID, globals kept
      wr_ctrl(32'h0800_0001);
      refill(20'h00200, 8'd5, 1'b0, 20'h02000);
      refill(20'h00201, 8'd5, 1'b1, 20'h02010);
      rd_ctrl("R4 victim after two", 32'h1000_0001);
      wr_ctrl(32'h1000_0000);
      refill(20'h00202, 8'd5, 1'b0, 20'h02020);
      refill(20'h00203, 8'd6, 1'b0, 20'h02030);
      do_op(2'd3, 20'h0, 8'd5);
      look("R3 pinned nonglobal cleared", 20'h00200, 8'd5, 1'b0, 20'h0);
      look("R3 pinned global kept", 20'h00201, 8'd9, 1'b1, 20'h02010);
      look("R3 unlocked match cleared", 20'h00202, 8'd5, 1'b0, 20'h0);
      look("R3 other asid kept", 20'h00203, 8'd6, 1'b1, 20'h02030);

      // R9: invalidate and refill in one cycle
      @(negedge clk);
      op_valid = 1'b1; op_kind = 2'd2; op_vpn = 20'h00400;
      rf_valid = 1'b1; rf_vpn = 20'h00400; rf_asid = 8'd1; rf_global = 1'b0; rf_ppn = 20'h44444;
      @(negedge clk);
      op_valid = 1'b0; rf_valid = 1'b0;
      look("R9 refill survives", 20'h00400, 8'd1, 1'b1, 20'h44444);

      // R6: round robin, ninth refill replaces the first
      for (int k = 0; k < 9; k++) refill(20'h00500 + 20'(k), 8'd1, 1'b0, 20'h00500 + 20'(k));
      look("R6 oldest replaced", 20'h00500, 8'd1, 1'b0, 20'h0);
      look("R6 second kept", 20'h00501, 8'd1, 1'b1, 20'h00501);
      look("R6 newest present", 20'h00508, 8'd1, 1'b1, 20'h00508);
      rd_ctrl("R6 control unchanged", 32'h1000_0000);

      done = 1'b1;
      finish_run();
   end

endmodule